// File: doc/BRIEF.md
# Fill-Path Performance Event Counter

This block is one programmable performance-monitoring counter on the miss path of a level-one data cache. Every cycle the line fill buffer pool reports three values. The first is how many misses for lines wanted by demand loads are still outstanding. The second is how many requests (loads, stores, software prefetches) tried to get a fill buffer entry and found the pool full; a request that retries while still blocked is counted again. The third is how many pool entries were allocated this cycle. Allocations come from any source: demand loads, stores, software and hardware prefetches, and dirty-line writebacks.

Software writes one control word. That word holds an event selector, a sub-event mask, a threshold and an enable bit. When the selector matches the block's event number and the counter is enabled, the chosen per-cycle quantity is added to a wrapping accumulator. The threshold changes this: with a nonzero threshold the block counts the cycles in which the chosen quantity reaches it, instead of summing the quantity. Counting is speculative. It follows the status signals directly and has no link to instruction retirement. The accumulator value is always visible on an output port.

Control word layout: bits [7:0] hold the event selector, bits [15:8] the sub-event mask, bits [23:16] the threshold, and bit 24 the enable.

Top module: `fill_event_counter`

## Requirements
- R1: After reset the count output is 0 and the counter is disabled. While it is disabled, activity on the status inputs leaves the count unchanged.
- R2: A control write with bit 24 set makes the count 0 after that edge. Counting with the new settings starts on the next cycle. A control write with bit 24 clear stops counting, and the count holds its value.
- R3: Only event selector 0x48 counts. Any other selector leaves the count unchanged whatever the status inputs do.
- R4: With mask 0x01 and threshold 0, the outstanding demand-miss number is added every cycle.
- R5: With mask 0x01 and threshold 1, the count rises by 1 in each cycle with at least one outstanding demand miss, and by 0 otherwise.
- R6: With mask 0x02 and threshold 0, the number of blocked fill-buffer requests in the cycle is added. Each retry of a blocked request counts again.
- R7: With mask 0x04 and threshold 0, the number of fill-buffer allocations in the cycle is added.
- R8: Mask 0x08, and every mask that is not one-hot (including 0x00), adds nothing.
- R9: A threshold N greater than 0 adds 1 in each cycle where the selected quantity is at least N, and 0 otherwise. This holds for every mask.
- R10: The count wraps to zero modulo 2^CNT_W on overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWrEn | input | 1 | Control word write strobe |
| ctrlWrData | input | 32 | Control word: selector, mask, threshold, enable |
| pendMiss | input | OCC_W | Outstanding demand-load misses this cycle |
| blockCnt | input | BLK_W | Requests blocked by a full pool this cycle |
| allocCnt | input | ALLOC_W | Fill buffer allocations this cycle |
| countValue | output | CNT_W | Accumulator value |

## Verification
The bench builds the counter with CNT_W=10, OCC_W=4, BLK_W=2 and ALLOC_W=3. With a 10-bit accumulator, a steady occupancy of 15 passes the wrap point in about seventy cycles, so R10 can be tested in a short run that the default 48-bit width would never reach. The 4-bit and 3-bit status widths let the bench drive every quantity up to its largest value and place thresholds both below and above the inputs it applies.

// File: rtl/fec_pkg.sv
package fec_pkg;
  localparam int THR_W     = 8;
  localparam int EVT_LSB   = 0;
  localparam int MASK_LSB  = 8;
  localparam int THR_LSB   = 16;
  localparam int EN_BIT    = 24;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_PEND  = 2'd1,
    SEL_BLOCK = 2'd2,
    SEL_ALLOC = 2'd3
  } selE;

  typedef struct packed {
    logic             clear;
    logic             countEn;
    selE              sel;
    logic [THR_W-1:0] thr;
  } strobeT;
endpackage

// File: rtl/fec_ctrl.sv
module fec_ctrl
  import fec_pkg::*;
#(
  parameter logic [7:0] EVT_CODE = 8'h48
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  output strobeT      strb
);
  logic             enQ;
  logic [7:0]       evtQ;
  logic [7:0]       maskQ;
  logic [THR_W-1:0] thrQ;
  selE              selD;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ   <= 1'b0;
      evtQ  <= '0;
      maskQ <= '0;
      thrQ  <= '0;
    end else if (wrEn) begin
      enQ   <= wrData[EN_BIT];
      evtQ  <= wrData[EVT_LSB +: 8];
      maskQ <= wrData[MASK_LSB +: 8];
      thrQ  <= wrData[THR_LSB +: THR_W];
    end
  end

  // Only a single-bit mask picks a quantity; 0x08 and all others count nothing.
  always_comb begin
    unique case (maskQ)
      8'h01:   selD = SEL_PEND;
      8'h02:   selD = SEL_BLOCK;
      8'h04:   selD = SEL_ALLOC;
      default: selD = SEL_NONE;
    endcase
  end

  always_comb begin
    strb.clear   = wrEn && wrData[EN_BIT];
    strb.countEn = !wrEn && enQ && (evtQ == EVT_CODE);
    strb.sel     = selD;
    strb.thr     = thrQ;
  end

  // R3: a foreign selector must never raise the count strobe
  a_r3_foreign_code: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[EVT_LSB +: 8] != EVT_CODE) |=> !strb.countEn);
endmodule

// File: rtl/fec_datapath.sv
module fec_datapath
  import fec_pkg::*;
#(
  parameter int CNT_W   = 48,
  parameter int OCC_W   = 4,
  parameter int BLK_W   = 2,
  parameter int ALLOC_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobeT             strb,
  input  logic [OCC_W-1:0]   pendMiss,
  input  logic [BLK_W-1:0]   blockCnt,
  input  logic [ALLOC_W-1:0] allocCnt,
  output logic [CNT_W-1:0]   accOut
);
  localparam int RAW_A = (OCC_W > BLK_W) ? OCC_W : BLK_W;
  localparam int RAW_W = (RAW_A > ALLOC_W) ? RAW_A : ALLOC_W;
  localparam int CMP_W = (RAW_W > THR_W) ? RAW_W : THR_W;

  logic [RAW_W-1:0] rawVal;
  logic [CMP_W-1:0] rawCmp;
  logic [CMP_W-1:0] thrCmp;
  logic             thrHit;
  logic [CNT_W-1:0] incr;
  logic [CNT_W-1:0] accQ;

  always_comb begin
    unique case (strb.sel)
      SEL_PEND:  rawVal = RAW_W'(pendMiss);
      SEL_BLOCK: rawVal = RAW_W'(blockCnt);
      SEL_ALLOC: rawVal = RAW_W'(allocCnt);
      default:   rawVal = '0;
    endcase
  end

  always_comb begin
    rawCmp = CMP_W'(rawVal);
    thrCmp = CMP_W'(strb.thr);
    thrHit = rawCmp >= thrCmp;
    if (strb.thr == '0) incr = CNT_W'(rawVal);
    else                incr = CNT_W'(thrHit);
  end

  always_ff @(posedge clk) begin
    if (!rstN)             accQ <= '0;
    else if (strb.clear)   accQ <= '0;
    else if (strb.countEn) accQ <= accQ + incr;
  end

  assign accOut = accQ;

  // R2: an enabling write zeroes the accumulator
  a_r2_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> accQ == '0);
  // R1: without a count strobe the value holds
  a_r1_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.clear && !strb.countEn) |=> $stable(accQ));
  // R8: no selected quantity means no growth
  a_r8_none_zero: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.clear && strb.sel == SEL_NONE) |=> $stable(accQ));
  // R9: threshold mode steps by at most one
  a_r9_thr_step: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.clear && strb.countEn && strb.thr != '0)
      |=> CNT_W'(accQ - $past(accQ)) <= CNT_W'(1));
endmodule

// File: rtl/fill_event_counter.sv
module fill_event_counter
  import fec_pkg::*;
#(
  parameter int         CNT_W    = 48,
  parameter int         OCC_W    = 4,
  parameter int         BLK_W    = 2,
  parameter int         ALLOC_W  = 3,
  parameter logic [7:0] EVT_CODE = 8'h48
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ctrlWrEn,
  input  logic [31:0]        ctrlWrData,
  input  logic [OCC_W-1:0]   pendMiss,
  input  logic [BLK_W-1:0]   blockCnt,
  input  logic [ALLOC_W-1:0] allocCnt,
  output logic [CNT_W-1:0]   countValue
);
  strobeT strb;

  fec_ctrl #(.EVT_CODE(EVT_CODE)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (ctrlWrEn),
    .wrData (ctrlWrData),
    .strb   (strb)
  );

  fec_datapath #(
    .CNT_W   (CNT_W),
    .OCC_W   (OCC_W),
    .BLK_W   (BLK_W),
    .ALLOC_W (ALLOC_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .pendMiss (pendMiss),
    .blockCnt (blockCnt),
    .allocCnt (allocCnt),
    .accOut   (countValue)
  );
endmodule

// File: tb/fill_event_counter_bench.sv
module fill_event_counter_bench;
  localparam int CNT_W = 10, OCC_W = 4, BLK_W = 2, ALLOC_W = 3;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               ctrlWrEn = 1'b0;
  logic [31:0]        ctrlWrData = '0;
  logic [OCC_W-1:0]   pendMiss = '0;
  logic [BLK_W-1:0]   blockCnt = '0;
  logic [ALLOC_W-1:0] allocCnt = '0;
  logic [CNT_W-1:0]   countValue;

  fill_event_counter #(.CNT_W(CNT_W), .OCC_W(OCC_W), .BLK_W(BLK_W),
                       .ALLOC_W(ALLOC_W)) u_fill_event_counter (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .pendMiss(pendMiss), .blockCnt(blockCnt), .allocCnt(allocCnt),
    .countValue(countValue)
  );

  always #5 clk = ~clk;

  int total = 0;
  int bad = 0;
  logic [CNT_W-1:0] expQ[$];
  string            tagQ[$];

  // reference model state
  logic [CNT_W-1:0] mAcc = '0;
  logic             mEn = 1'b0;
  logic [7:0]       mEvt = '0, mMask = '0, mThr = '0;

  function automatic int rawOf(int p, int b, int a);
    case (mMask)
      8'h01:   return p;
      8'h02:   return b;
      8'h04:   return a;
      default: return 0;
    endcase
  endfunction

  task automatic cfg(input logic [7:0] evt, input logic [7:0] mask,
                     input logic [7:0] thr, input logic en, input string tag);
    @(negedge clk);
    ctrlWrEn   = 1'b1;
    ctrlWrData = {7'd0, en, thr, mask, evt};
    mEn = en; mEvt = evt; mMask = mask; mThr = thr;
    if (en) mAcc = '0;
    expQ.push_back(mAcc);
    tagQ.push_back(tag);
  endtask

  task automatic step(input int p, input int b, input int a, input string tag);
    int raw;
    int inc;
    @(negedge clk);
    ctrlWrEn = 1'b0;
    pendMiss = OCC_W'(p);
    blockCnt = BLK_W'(b);
    allocCnt = ALLOC_W'(a);
    raw = rawOf(p, b, a);
    if (mThr == 0) inc = raw;
    else           inc = (raw >= int'(mThr)) ? 1 : 0;
    if (mEn && mEvt == 8'h48) mAcc = mAcc + CNT_W'(inc);
    expQ.push_back(mAcc);
    tagQ.push_back(tag);
  endtask

  // monitor: compare one expected item per cycle, after the edge settles
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        logic [CNT_W-1:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        total++;
        if (countValue !== e) begin
          bad++;
          $display("FAIL %s: count=%0d expected=%0d", t, countValue, e);
        end
      end
    end
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not finish, got=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    total++;
    if (countValue !== '0) begin
      bad++;
      $display("FAIL R1: reset count=%0d expected=0", countValue);
    end
    // R1: disabled counter ignores activity
    step(9, 3, 7, "R1"); step(15, 2, 4, "R1");
    // R2 + R4: enabling write clears, occupancy summed
    cfg(8'h48, 8'h01, 8'h00, 1'b1, "R2");
    step(3, 3, 7, "R4"); step(0, 1, 1, "R4"); step(5, 0, 0, "R4"); step(7, 2, 3, "R4");
    // R5: cycles with any outstanding miss
    cfg(8'h48, 8'h01, 8'h01, 1'b1, "R2");
    step(0, 3, 7, "R5"); step(2, 0, 0, "R5"); step(15, 0, 0, "R5"); step(1, 0, 0, "R5");
    // R6: blocked attempts, retries counted again
    cfg(8'h48, 8'h02, 8'h00, 1'b1, "R6");
    step(9, 3, 7, "R6"); step(9, 1, 7, "R6"); step(9, 0, 7, "R6"); step(9, 2, 7, "R6");
    // R7: allocations from all sources
    cfg(8'h48, 8'h04, 8'h00, 1'b1, "R7");
    step(15, 3, 7, "R7"); step(15, 3, 4, "R7"); step(0, 0, 0, "R7");
    // R9: thresholds on allocations and occupancy
    cfg(8'h48, 8'h04, 8'h02, 1'b1, "R9");
    step(0, 0, 1, "R9"); step(0, 0, 2, "R9"); step(0, 0, 5, "R9");
    cfg(8'h48, 8'h01, 8'h04, 1'b1, "R9");
    step(3, 0, 0, "R9"); step(4, 0, 0, "R9"); step(9, 0, 0, "R9");
    // R8: mask 0x08 and non-one-hot masks
    cfg(8'h48, 8'h08, 8'h00, 1'b1, "R8");
    step(15, 3, 7, "R8"); step(15, 3, 7, "R8");
    cfg(8'h48, 8'h03, 8'h00, 1'b1, "R8");
    step(15, 3, 7, "R8"); step(15, 3, 7, "R8");
    cfg(8'h48, 8'h00, 8'h01, 1'b1, "R8");
    step(15, 3, 7, "R8");
    // R3: foreign selector
    cfg(8'h47, 8'h01, 8'h00, 1'b1, "R3");
    step(15, 3, 7, "R3"); step(15, 3, 7, "R3");
    // R10: wrap past 2^CNT_W
    cfg(8'h48, 8'h01, 8'h00, 1'b1, "R10");
    for (int i = 0; i < 80; i++) step(15, 0, 0, "R10");
    // R2: disabling write holds value
    cfg(8'h48, 8'h01, 8'h00, 1'b0, "R2");
    step(15, 3, 7, "R2"); step(15, 3, 7, "R2");
    repeat (3) @(posedge clk);
    #2;
    if (expQ.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard: left=%0d expected=0", expQ.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule